// File: doc/BRIEF.md
# Seconds Counter With Match Alarm

This peripheral keeps wall-clock time as a 32-bit count of seconds that runs freely and rolls over from all-ones to zero. A prescaler divides the system clock into one tick per `TICK_DIV` cycles, and each tick advances the count by one. Software reaches the block through a single-cycle register port. A write takes effect at the clock edge where `bus_we` is high. Read data is combinational from `bus_addr`.

Software can load a new count, program a match value and handle one alarm interrupt. The alarm has a raw status view, a one-bit enable mask and a masked status view. A two-state alarm machine holds the raw status. Its states are `ALM_QUIET` (no alarm pending) and `ALM_RAISED` (alarm pending). The transition QUIET to RAISED is taken on a match hit. The transition RAISED to QUIET is taken on a clear write when no hit occurs in the same cycle. A hit happens only at an event: a tick, a load write or a match write. It requires the count and the match value that follow that event to be equal. This means the alarm fires once when the count enters the match value, not for every cycle the two stay equal.

The top of the 4 KB window holds a fixed identification region.

Top module: `rtc_alarm_unit`

## Requirements
- R1: After reset the count, the match value, the mask, the raw status and the load readback all read 0, and `alarm_irq` is low.
- R2: The count at offset 0x00 advances by exactly one every `TICK_DIV` clock cycles and wraps from 0xFFFFFFFF to 0. Writes to 0x00 are ignored.
- R3: Raw status (offset 0x14, bit 0) becomes 1 at the tick on which the count enters the match value, including a match across the wrap. It stays 1 until cleared, and it is not set again while the count stays equal to the match value.
- R4: A write to 0x04 stores the match value, which reads back at 0x04. If the new value equals the count in effect after that edge, raw status is set at the same edge.
- R5: A write to 0x08 makes the count continue from the written value and restarts the prescaler, so the next increment comes `TICK_DIV` cycles later. The new count is compared at once against the match value. Offset 0x08 reads back the last value loaded.
- R6: A write to the mask at 0x10 keeps only bit 0 of the data, and a read of 0x10 returns that single bit with all other bits 0.
- R7: `alarm_irq` and the masked status at 0x18 both equal raw status AND mask.
- R8: The control register at 0x0C always reads 1, and writes to it change nothing.
- R9: Reads of offsets 0xFE0 to 0xFFC return one identification byte per word in bits 7:0, with the upper bits 0. In address order the bytes are 0x31, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R10: Any write to 0x1C clears raw status whatever the data, but a hit in the same cycle wins. Reads of 0x1C and of unmapped offsets return 0. Writes to 0x14 and 0x18 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte offset in the 4 KB window (word aligned) |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| alarm_irq | output | 1 | Alarm interrupt, level, active high |

## Verification
A wrong count or a prescaler that has lost its phase shows up at offset 0x00 within one tick period. It also moves the cycle in which raw status rises, so `alarm_irq` appears one period early or late. A raw status flag stuck in `ALM_RAISED` or in `ALM_QUIET` is visible on the next read of 0x14 or 0x18, and on `alarm_irq` in the same cycle once the mask is set. The bench compares every read and the interrupt pin against a cycle-level model on every step, so a divergence is reported in the cycle it first reaches a port.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam logic [11:0] OFS_COUNT = 12'h000;
    localparam logic [11:0] OFS_MATCH = 12'h004;
    localparam logic [11:0] OFS_LOAD  = 12'h008;
    localparam logic [11:0] OFS_CTRL  = 12'h00C;
    localparam logic [11:0] OFS_MASK  = 12'h010;
    localparam logic [11:0] OFS_RAW   = 12'h014;
    localparam logic [11:0] OFS_MIS   = 12'h018;
    localparam logic [11:0] OFS_CLEAR = 12'h01C;
    localparam logic [6:0]  ID_PAGE   = 7'h7F;   // addr[11:5] of 0xFE0..0xFFC

    typedef enum logic {ALM_QUIET, ALM_RAISED} alm_state_e;

    function automatic logic [7:0] id_byte(input logic [2:0] idx);
        case (idx)
            3'd0:    return 8'h31;
            3'd1:    return 8'h10;
            3'd2:    return 8'h14;
            3'd3:    return 8'h00;
            3'd4:    return 8'h0D;
            3'd5:    return 8'hF0;
            3'd6:    return 8'h05;
            default: return 8'hB1;
        endcase
    endfunction
endpackage

// File: rtl/rtc_tick_gen.sv
module rtc_tick_gen #(
    parameter int unsigned TICK_DIV = 125_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int unsigned DW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [DW-1:0] LAST = DW'(TICK_DIV - 1);

    logic [DW-1:0] div_q;

    assign tick = (div_q == LAST) && !restart;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                div_q <= '0;
        else if (restart || tick)  div_q <= '0;
        else                       div_q <= div_q + 1'b1;
    end
endmodule

// File: rtl/rtc_sec_counter.sv
module rtc_sec_counter #(
    parameter int unsigned CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          load_en,
    input  logic [CW-1:0] load_val,
    output logic [CW-1:0] count_nxt,
    output logic [CW-1:0] count_q
);
    always_comb begin
        if (load_en)   count_nxt = load_val;
        else if (tick) count_nxt = count_q + 1'b1;
        else           count_nxt = count_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_nxt;
    end
endmodule

// File: rtl/rtc_alarm_fsm.sv
module rtc_alarm_fsm
    import rtc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic clear,
    output logic raw
);
    alm_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ALM_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ALM_QUIET:  if (hit) state_d = ALM_RAISED;
            ALM_RAISED: if (clear && !hit) state_d = ALM_QUIET;
            default:    state_d = ALM_QUIET;
        endcase
    end

    assign raw = (state_q == ALM_RAISED);
endmodule

// File: rtl/rtc_alarm_unit.sv
module rtc_alarm_unit
    import rtc_pkg::*;
#(
    parameter int unsigned TICK_DIV = 125_000_000,
    parameter int unsigned DATA_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [11:0]       bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              alarm_irq
);
    logic              wr_load, wr_match, wr_mask, wr_clear;
    logic              tick;
    logic [DATA_W-1:0] count_q, count_nxt;
    logic [DATA_W-1:0] match_q, match_nxt, load_q;
    logic              mask_q, raw_q, hit;

    assign wr_load  = bus_we && (bus_addr == OFS_LOAD);
    assign wr_match = bus_we && (bus_addr == OFS_MATCH);
    assign wr_mask  = bus_we && (bus_addr == OFS_MASK);
    assign wr_clear = bus_we && (bus_addr == OFS_CLEAR);

    rtc_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .restart(wr_load), .tick(tick)
    );

    rtc_sec_counter #(.CW(DATA_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .load_en(wr_load),
        .load_val(bus_wdata), .count_nxt(count_nxt), .count_q(count_q)
    );

    assign match_nxt = wr_match ? bus_wdata : match_q;
    // Compare only at an event, so equality that persists fires once.
    assign hit = (tick || wr_load || wr_match) && (count_nxt == match_nxt);

    rtc_alarm_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .hit(hit), .clear(wr_clear), .raw(raw_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            match_q <= '0;
            load_q  <= '0;
            mask_q  <= 1'b0;
        end else begin
            match_q <= match_nxt;
            if (wr_load) load_q <= bus_wdata;
            if (wr_mask) mask_q <= bus_wdata[0];
        end
    end

    assign alarm_irq = raw_q & mask_q;

    always_comb begin
        bus_rdata = '0;
        if (bus_addr[11:5] == ID_PAGE) begin
            bus_rdata[7:0] = id_byte(bus_addr[4:2]);
        end else begin
            case (bus_addr)
                OFS_COUNT: bus_rdata = count_q;
                OFS_MATCH: bus_rdata = match_q;
                OFS_LOAD:  bus_rdata = load_q;
                OFS_CTRL:  bus_rdata[0] = 1'b1;
                OFS_MASK:  bus_rdata[0] = mask_q;
                OFS_RAW:   bus_rdata[0] = raw_q;
                OFS_MIS:   bus_rdata[0] = raw_q & mask_q;
                default:   bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/rtc_alarm_chk.sv
module rtc_alarm_chk
    import rtc_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic [11:0]  bus_addr,
    input logic         bus_we,
    input logic [W-1:0] bus_rdata,
    input logic [W-1:0] cnt,
    input logic [W-1:0] match,
    input logic         raw
);
    // R2: outside a load, the count holds or steps by one
    a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_addr == OFS_LOAD) |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1));

    // R3 / R4: raw status only rises when count and match agree
    a_r3_rise_at_match: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(raw) |-> (cnt == match));

    // R10: a clear write leaves raw low unless the count moved
    a_r10_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFS_CLEAR && !(bus_addr == OFS_MATCH))
        |=> (!raw || cnt != $past(cnt)));

    // R6: mask reads carry one bit only
    a_r6_mask_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFS_MASK) |-> (bus_rdata[W-1:1] == '0));

    // R8: control always reads as enabled
    a_r8_ctrl_one: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFS_CTRL) |-> (bus_rdata == W'(1)));
endmodule

bind rtc_alarm_unit rtc_alarm_chk #(.W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_rdata(bus_rdata), .cnt(count_q), .match(match_q), .raw(raw_q)
);

// File: tb/sim_rtc_alarm_unit.sv
module sim_rtc_alarm_unit;
    localparam int unsigned DIV = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        alarm_irq;

    int checks = 0;
    int fails  = 0;

    // reference state
    int unsigned m_div = 0;
    logic [31:0] m_cnt = '0, m_mt = '0, m_lr = '0;
    logic        m_msk = 1'b0, m_raw = 1'b0;

    rtc_alarm_unit #(.TICK_DIV(DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .alarm_irq(alarm_irq)
    );

    always #4 clk = ~clk;

    function automatic logic [31:0] exp_read(input logic [11:0] a);
        logic [7:0] ids [8] = '{8'h31, 8'h10, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
        if (a >= 12'hFE0) return {24'h0, ids[a[4:2]]};
        case (a)
            12'h000: return m_cnt;
            12'h004: return m_mt;
            12'h008: return m_lr;
            12'h00C: return 32'd1;
            12'h010: return {31'h0, m_msk};
            12'h014: return {31'h0, m_raw};
            12'h018: return {31'h0, m_raw & m_msk};
            default: return 32'h0;
        endcase
    endfunction

    function automatic string req_of(input logic [11:0] a);
        if (a >= 12'hFE0) return "R9";
        case (a)
            12'h000: return "R2";
            12'h004: return "R4";
            12'h008: return "R5";
            12'h00C: return "R8";
            12'h010: return "R6";
            12'h014: return "R3";
            12'h018: return "R7";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic model_edge(input logic [11:0] a, input logic we, input logic [31:0] wd);
        logic ld, mw, clr, tk, hit;
        logic [31:0] n_cnt, n_mt;
        ld  = we && a == 12'h008;
        mw  = we && a == 12'h004;
        clr = we && a == 12'h01C;
        tk  = (m_div == DIV - 1) && !ld;
        n_cnt = ld ? wd : (tk ? m_cnt + 32'd1 : m_cnt);
        n_mt  = mw ? wd : m_mt;
        hit = (tk || ld || mw) && (n_cnt == n_mt);
        m_raw = hit ? 1'b1 : (clr ? 1'b0 : m_raw);
        m_div = (ld || tk) ? 0 : m_div + 1;
        m_cnt = n_cnt;
        m_mt  = n_mt;
        if (ld) m_lr = wd;
        if (we && a == 12'h010) m_msk = wd[0];
    endtask

    // one bus cycle: drive at negedge, check ports, then advance the model at the edge
    task automatic step(input logic [11:0] a, input logic we, input logic [31:0] wd);
        @(negedge clk);
        bus_addr = a; bus_we = we; bus_wdata = wd;
        #1;
        if (!we) check(req_of(a), bus_rdata, exp_read(a));
        check("R7", {31'h0, alarm_irq}, {31'h0, m_raw & m_msk});
        @(posedge clk);
        model_edge(a, we, wd);
    endtask

    task automatic rd(input logic [11:0] a);
        step(a, 1'b0, 32'h0);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        step(a, 1'b1, d);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        logic [11:0] addrs [12] = '{12'h000, 12'h004, 12'h008, 12'h00C, 12'h010, 12'h014,
                                    12'h018, 12'h01C, 12'h020, 12'hFE0, 12'hFFC, 12'h7F0};
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        foreach (addrs[i]) rd(addrs[i]);
        // R9: full identification region
        for (int i = 0; i < 8; i++) rd(12'hFE0 + 12'(i * 4));
        // R8: control write ignored
        wr(12'h00C, 32'h0); rd(12'h00C);
        // R6: only bit 0 kept
        wr(12'h010, 32'hFFFF_FFFE); rd(12'h010);
        wr(12'h010, 32'h0000_0003); rd(12'h010);
        // R3: alarm across the wrap
        wr(12'h004, 32'h0000_0001);
        wr(12'h008, 32'hFFFF_FFFE); rd(12'h008);
        for (int i = 0; i < 3 * DIV + 2; i++) rd(12'h014);
        rd(12'h000); rd(12'h018);
        // R10: clear with zero data, stays clear while equal
        wr(12'h01C, 32'h0);
        for (int i = 0; i < 3; i++) rd(12'h014);
        // R10: read-only writes ignored
        wr(12'h000, 32'h1234_5678); wr(12'h014, 32'h1); wr(12'h018, 32'h1);
        rd(12'h000); rd(12'h014); rd(12'h01C);
        // R4: match equal to current count fires at once
        wr(12'h004, m_cnt); rd(12'h014); rd(12'h004);
        wr(12'h01C, 32'hFFFF_FFFF);
        // R5: load equal to match fires, period restarts
        wr(12'h008, m_mt); rd(12'h014);
        wr(12'h01C, 32'h0);
        for (int i = 0; i < DIV + 1; i++) rd(12'h000);
        // R2: random mix
        for (int n = 0; n < 4000; n++) begin
            logic [11:0] a;
            logic [31:0] d;
            int unsigned r;
            r = $urandom_range(0, 11);
            a = addrs[r];
            if ($urandom_range(0, 3) == 0) begin
                d = $urandom();
                if (a == 12'h004) d = m_cnt + 32'($urandom_range(0, 2));
                if (a == 12'h008) d = ($urandom_range(0, 1) == 0) ? m_mt - 32'd1 : 32'hFFFF_FFFF;
                wr(a, d);
            end else begin
                rd(a);
            end
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule